// File: doc/BRIEF.md
# Paired-Page Pending/Queued State Access Port

This block is a memory-mapped slave that gives software direct access to the two-bit coalescing state pairs held in event-queue descriptors. Each pair has a pending bit P and a queued bit Q. Every queue owns two adjacent pages of address space. The even page acts on the queue's notify pair and the odd page acts on its escalate pair. Both pairs live in the same descriptor word.

The offset inside a page selects the operation, and this includes loads that force the pair to a chosen value. When an access is accepted, the block decodes the queue index, the page parity and the operation. It fetches the descriptor word through a read port and applies the selected transition to the selected pair. It writes the word back only when the pair has changed, then returns a single 64-bit response.

The page size is a parameter, PAGE_SHIFT, which must be 12 or 16. Any other value stops elaboration with an error.

Top module: `pq_page_port`

## Requirements
- R1: The queue index is `req_addr >> (PAGE_SHIFT+1)` and is presented on `desc_rd_idx`. Address bit `PAGE_SHIFT` selects the pair: 0 selects the notify pair at descriptor bits [NOTIFY_LSB+1:NOTIFY_LSB], and 1 selects the escalate pair at bits [ESCAL_LSB+1:ESCAL_LSB]. In each pair the upper bit is P and the lower bit is Q.
- R2: Only 8-byte big-endian accesses are accepted. Any other access is answered with `rsp_err`=1, without a descriptor read. A rejected load returns all ones and a rejected store returns zero.
- R3: A load at offset 0x800–0xBFF (offset = address bits [11:0]) returns the pair in `rsp_data[1:0]` with all upper bits zero, and it never causes a write-back.
- R4: A load at offset 0xC00–0xFFF sets the pair to offset bits [9:8] (bit 9 = P) and returns the old pair in `rsp_data[1:0]`.
- R5: A load at offset 0x000–0x7FF performs the EOI step. It returns 1 in `rsp_data` if the step reports a notification and 0 otherwise.
- R6: The EOI step gives pair 10 with notification when Q was 1, and pair 00 without notification when Q was 0.
- R7: A store at offset 0x000–0x3FF performs the trigger step: 00 becomes 10 with notification, 10 and 11 become 11, and 01 stays 01. Only the first case notifies.
- R8: A store at offset 0x400–0x7FF performs the EOI step. A store at 0x800 or above is rejected with `rsp_err`=1 and no descriptor read. For stores, `rsp_notify` reports the step's notification and `rsp_data` is zero.
- R9: If the descriptor is not found (`desc_found`=0) or its valid bit VALID_BIT is 0, the access responds with `rsp_err`=1 and nothing is written back. A load in this case returns all ones.
- R10: `desc_wr_valid` pulses for one cycle with the response only when the pair value changed. The written word equals the fetched word with only the selected pair replaced, and it goes to the same index.
- R11: `req_ready` is high only while no access is in progress. A rejected access responds on the cycle after acceptance. A fetched access holds `desc_rd_req` and `desc_rd_idx` steady until `desc_rd_ack`, and it responds on the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address within the port's window |
| req_bytes | input | 4 | Access size in bytes |
| req_big_endian | input | 1 | Access byte order is big-endian |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 64 | Load result |
| rsp_err | output | 1 | Access rejected or descriptor unusable |
| rsp_notify | output | 1 | Step reported a notification |
| desc_rd_req | output | 1 | Descriptor fetch request, held until acknowledged |
| desc_rd_idx | output | QIDX_W | Queue index to fetch |
| desc_rd_ack | input | 1 | Fetch data valid |
| desc_found | input | 1 | Descriptor exists |
| desc_rd_word | input | DESC_W | Fetched descriptor word |
| desc_wr_valid | output | 1 | Write-back strobe |
| desc_wr_idx | output | QIDX_W | Write-back queue index |
| desc_wr_word | output | DESC_W | Updated descriptor word |

## Verification
On every cycle the assertions check the port handshake rules. They confirm that the fetch request is held until acknowledged and that the response follows the acknowledge. They confirm that the fetch index matches the decoded address. They also confirm that write-backs occur only alongside a clean response, only with a changed word, and never after a GET. They confirm that rejected loads return all ones and that stores return zero data. Only the bench's sweep can show that each transition table is correct for every starting pair, on both page parities and every operation range, and that the untouched pair and other descriptor bits survive a write-back.

// File: rtl/pq_page_pkg.sv
package pq_page_pkg;

    localparam int ACC_BYTES = 8;
    localparam int DATA_W    = 64;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LD_EOI,
        OP_LD_GET,
        OP_LD_SET,
        OP_ST_TRIG,
        OP_ST_EOI
    } pq_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_FETCH
    } port_st_e;

endpackage

// File: rtl/pq_addr_decode.sv
module pq_addr_decode
    import pq_page_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 16,
    localparam int QIDX_W    = ADDR_W - PAGE_SHIFT - 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic [3:0]        nbytes,
    input  logic              big_end,
    output logic [QIDX_W-1:0] qidx,
    output logic              odd_page,
    output pq_op_e            op,
    output logic [1:0]        set_val,
    output logic              reject
);

    logic [11:0] off;
    logic        shape_bad;
    logic        unused_addr_bits;

    assign off              = addr[11:0];
    assign qidx             = addr[ADDR_W-1:PAGE_SHIFT+1];
    assign odd_page         = addr[PAGE_SHIFT];
    assign set_val          = off[9:8];
    assign shape_bad        = (nbytes != 4'(ACC_BYTES)) || !big_end;
    assign unused_addr_bits = ^addr;

    always_comb begin
        op     = OP_NONE;
        reject = shape_bad;
        if (is_write) begin
            unique case (off[11:10])
                2'b00:   op = OP_ST_TRIG;
                2'b01:   op = OP_ST_EOI;
                default: reject = 1'b1;
            endcase
        end else if (!off[11]) begin
            op = OP_LD_EOI;
        end else if (!off[10]) begin
            op = OP_LD_GET;
        end else begin
            op = OP_LD_SET;
        end
        if (reject) begin
            op = OP_NONE;
        end
    end

endmodule

// File: rtl/pq_pair_step.sv
module pq_pair_step
    import pq_page_pkg::*;
(
    input  pq_op_e            op,
    input  logic [1:0]        set_val,
    input  logic [1:0]        old_pair,
    output logic [1:0]        new_pair,
    output logic              notify,
    output logic [DATA_W-1:0] ld_val
);

    always_comb begin
        new_pair = old_pair;
        notify   = 1'b0;
        ld_val   = '0;
        unique case (op)
            OP_LD_EOI, OP_ST_EOI: begin
                if (old_pair[0]) begin
                    new_pair = 2'b10;
                    notify   = 1'b1;
                end else begin
                    new_pair = 2'b00;
                end
                ld_val = DATA_W'(notify);
            end
            OP_LD_GET: begin
                ld_val = DATA_W'(old_pair);
            end
            OP_LD_SET: begin
                new_pair = set_val;
                ld_val   = DATA_W'(old_pair);
            end
            OP_ST_TRIG: begin
                unique case (old_pair)
                    2'b00: begin
                        new_pair = 2'b10;
                        notify   = 1'b1;
                    end
                    2'b01:   new_pair = 2'b01;
                    default: new_pair = 2'b11;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pq_pair_field.sv
module pq_pair_field #(
    parameter int DESC_W     = 32,
    parameter int NOTIFY_LSB = 16,
    parameter int ESCAL_LSB  = 18
) (
    input  logic [DESC_W-1:0] word,
    input  logic              odd_page,
    input  logic [1:0]        new_pair,
    output logic [1:0]        old_pair,
    output logic [DESC_W-1:0] merged
);

    always_comb begin
        merged = word;
        if (odd_page) begin
            old_pair                        = word[ESCAL_LSB+1:ESCAL_LSB];
            merged[ESCAL_LSB+1:ESCAL_LSB]   = new_pair;
        end else begin
            old_pair                        = word[NOTIFY_LSB+1:NOTIFY_LSB];
            merged[NOTIFY_LSB+1:NOTIFY_LSB] = new_pair;
        end
    end

endmodule

// File: rtl/pq_page_port.sv
module pq_page_port
    import pq_page_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 16,
    parameter int DESC_W     = 32,
    parameter int VALID_BIT  = 31,
    parameter int NOTIFY_LSB = 16,
    parameter int ESCAL_LSB  = 18,
    localparam int QIDX_W    = ADDR_W - PAGE_SHIFT - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_bytes,
    input  logic              req_big_endian,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              rsp_err,
    output logic              rsp_notify,
    output logic              desc_rd_req,
    output logic [QIDX_W-1:0] desc_rd_idx,
    input  logic              desc_rd_ack,
    input  logic              desc_found,
    input  logic [DESC_W-1:0] desc_rd_word,
    output logic              desc_wr_valid,
    output logic [QIDX_W-1:0] desc_wr_idx,
    output logic [DESC_W-1:0] desc_wr_word
);

    if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_page_shift
        $error("pq_page_port: PAGE_SHIFT must be 12 or 16");
    end

    typedef struct packed {
        port_st_e          st;
        logic [QIDX_W-1:0] qidx;
        logic              odd;
        pq_op_e            op;
        logic [1:0]        setv;
        logic              rd_req;
        logic              rsp_v;
        logic [63:0]       rsp_d;
        logic              rsp_err;
        logic              rsp_n;
        logic              wr_v;
        logic [QIDX_W-1:0] wr_idx;
        logic [DESC_W-1:0] wr_word;
    } port_state_t;

    port_state_t state_d, state_q;

    logic [QIDX_W-1:0] dec_qidx;
    logic              dec_odd;
    pq_op_e            dec_op;
    logic [1:0]        dec_setv;
    logic              dec_reject;

    logic [1:0]        fld_old;
    logic [1:0]        step_new;
    logic              step_notify;
    logic [63:0]       step_ld;
    logic [DESC_W-1:0] fld_merged;
    logic              desc_ok;
    logic              op_is_load;

    pq_addr_decode #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_decode (
        .addr    (req_addr),
        .is_write(req_write),
        .nbytes  (req_bytes),
        .big_end (req_big_endian),
        .qidx    (dec_qidx),
        .odd_page(dec_odd),
        .op      (dec_op),
        .set_val (dec_setv),
        .reject  (dec_reject)
    );

    pq_pair_field #(
        .DESC_W    (DESC_W),
        .NOTIFY_LSB(NOTIFY_LSB),
        .ESCAL_LSB (ESCAL_LSB)
    ) u_field (
        .word    (desc_rd_word),
        .odd_page(state_q.odd),
        .new_pair(step_new),
        .old_pair(fld_old),
        .merged  (fld_merged)
    );

    pq_pair_step u_step (
        .op      (state_q.op),
        .set_val (state_q.setv),
        .old_pair(fld_old),
        .new_pair(step_new),
        .notify  (step_notify),
        .ld_val  (step_ld)
    );

    assign desc_ok    = desc_found && desc_rd_word[VALID_BIT];
    assign op_is_load = (state_q.op == OP_LD_EOI) || (state_q.op == OP_LD_GET) ||
                        (state_q.op == OP_LD_SET);

    always_comb begin
        state_d       = state_q;
        state_d.rsp_v = 1'b0;
        state_d.wr_v  = 1'b0;
        unique case (state_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_reject) begin
                        state_d.rsp_v   = 1'b1;
                        state_d.rsp_err = 1'b1;
                        state_d.rsp_n   = 1'b0;
                        state_d.rsp_d   = req_write ? 64'h0 : '1;
                    end else begin
                        state_d.st     = ST_FETCH;
                        state_d.rd_req = 1'b1;
                        state_d.qidx   = dec_qidx;
                        state_d.odd    = dec_odd;
                        state_d.op     = dec_op;
                        state_d.setv   = dec_setv;
                    end
                end
            end
            ST_FETCH: begin
                if (desc_rd_ack) begin
                    state_d.st     = ST_IDLE;
                    state_d.rd_req = 1'b0;
                    state_d.rsp_v  = 1'b1;
                    if (!desc_ok) begin
                        state_d.rsp_err = 1'b1;
                        state_d.rsp_n   = 1'b0;
                        state_d.rsp_d   = op_is_load ? '1 : 64'h0;
                    end else begin
                        state_d.rsp_err = 1'b0;
                        state_d.rsp_n   = step_notify;
                        state_d.rsp_d   = op_is_load ? step_ld : 64'h0;
                        if (step_new != fld_old) begin
                            state_d.wr_v    = 1'b1;
                            state_d.wr_idx  = state_q.qidx;
                            state_d.wr_word = fld_merged;
                        end
                    end
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_ready     = (state_q.st == ST_IDLE);
    assign rsp_valid     = state_q.rsp_v;
    assign rsp_data      = state_q.rsp_d;
    assign rsp_err       = state_q.rsp_err;
    assign rsp_notify    = state_q.rsp_n;
    assign desc_rd_req   = state_q.rd_req;
    assign desc_rd_idx   = state_q.qidx;
    assign desc_wr_valid = state_q.wr_v;
    assign desc_wr_idx   = state_q.wr_idx;
    assign desc_wr_word  = state_q.wr_word;

endmodule

// File: rtl/pq_page_port_chk.sv
module pq_page_port_chk #(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 16,
    parameter int DESC_W     = 32,
    localparam int QIDX_W    = ADDR_W - PAGE_SHIFT - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [63:0]       rsp_data,
    input logic              rsp_err,
    input logic              desc_rd_req,
    input logic [QIDX_W-1:0] desc_rd_idx,
    input logic              desc_rd_ack,
    input logic [DESC_W-1:0] desc_rd_word,
    input logic              desc_wr_valid,
    input logic [QIDX_W-1:0] desc_wr_idx,
    input logic [DESC_W-1:0] desc_wr_word
);

    logic              cap_write;
    logic              cap_get;
    logic [QIDX_W-1:0] cap_qidx;
    logic              unused_cap_bits;

    assign unused_cap_bits = ^req_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_write <= 1'b0;
            cap_get   <= 1'b0;
            cap_qidx  <= '0;
        end else if (req_valid && req_ready) begin
            cap_write <= req_write;
            cap_get   <= !req_write && (req_addr[11:10] == 2'b10);
            cap_qidx  <= req_addr[ADDR_W-1:PAGE_SHIFT+1];
        end
    end

    assert_idx_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_req |-> desc_rd_idx == cap_qidx);

    assert_reject_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err && !cap_write |-> &rsp_data);

    assert_get_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && cap_get |-> !desc_wr_valid);

    assert_store_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && cap_write |-> rsp_data == 64'h0);

    assert_wb_clean_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_valid |-> rsp_valid && !rsp_err);

    assert_wb_changed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_valid |-> desc_wr_word != $past(desc_rd_word) &&
                          desc_wr_idx == $past(desc_rd_idx));

    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_req |-> !req_ready);

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_req && !desc_rd_ack |=> desc_rd_req && $stable(desc_rd_idx));

    assert_rsp_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_req && desc_rd_ack |=> rsp_valid && !desc_rd_req);

endmodule

bind pq_page_port pq_page_port_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .DESC_W    (DESC_W)
) u_pq_page_port_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err),
    .desc_rd_req  (desc_rd_req),
    .desc_rd_idx  (desc_rd_idx),
    .desc_rd_ack  (desc_rd_ack),
    .desc_rd_word (desc_rd_word),
    .desc_wr_valid(desc_wr_valid),
    .desc_wr_idx  (desc_wr_idx),
    .desc_wr_word (desc_wr_word)
);

// File: tb/test_pq_page_port.sv
`timescale 1ns/1ps
module test_pq_page_port;

    localparam int AW  = 16;
    localparam int PS  = 12;
    localparam int DW  = 32;
    localparam int VB  = 31;
    localparam int NL  = 16;
    localparam int EL  = 18;
    localparam int QW  = AW - PS - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_bytes = 4'd8;
    logic          req_big_endian = 1'b1;
    logic          rsp_valid;
    logic [63:0]   rsp_data;
    logic          rsp_err;
    logic          rsp_notify;
    logic          desc_rd_req;
    logic [QW-1:0] desc_rd_idx;
    logic          desc_rd_ack = 1'b0;
    logic          desc_found = 1'b0;
    logic [DW-1:0] desc_rd_word = '0;
    logic          desc_wr_valid;
    logic [QW-1:0] desc_wr_idx;
    logic [DW-1:0] desc_wr_word;

    always #2.5 clk = ~clk;

    pq_page_port #(
        .ADDR_W(AW), .PAGE_SHIFT(PS), .DESC_W(DW),
        .VALID_BIT(VB), .NOTIFY_LSB(NL), .ESCAL_LSB(EL)
    ) i_pq_page_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_bytes(req_bytes),
        .req_big_endian(req_big_endian), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .rsp_notify(rsp_notify), .desc_rd_req(desc_rd_req),
        .desc_rd_idx(desc_rd_idx), .desc_rd_ack(desc_rd_ack), .desc_found(desc_found),
        .desc_rd_word(desc_rd_word), .desc_wr_valid(desc_wr_valid),
        .desc_wr_idx(desc_wr_idx), .desc_wr_word(desc_wr_word)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // observed results of one access
    logic [63:0]   g_data;
    logic          g_err, g_ntf, g_wb, g_rd;
    logic [DW-1:0] g_wb_word;
    logic [QW-1:0] g_wb_idx, g_rd_idx;
    int            g_lat;

    // expected results
    logic [63:0]   e_data;
    logic          e_err, e_ntf, e_wb, e_rd;
    logic [DW-1:0] e_wb_word;
    int            e_lat;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [3:0] nb,
                          input bit be, input bit found, input logic [DW-1:0] word,
                          input int ack_delay);
        bit acked = 1'b0;
        bit got = 1'b0;
        int wait_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_bytes = nb; req_big_endian = be;
        @(negedge clk);
        req_valid = 1'b0;
        g_rd = 1'b0; g_wb = 1'b0; g_lat = -1; g_rd_idx = '0;
        for (int c = 0; c < 12 && !got; c++) begin
            desc_rd_ack = 1'b0;
            if (rsp_valid) begin
                got = 1'b1;
                g_data = rsp_data; g_err = rsp_err; g_ntf = rsp_notify;
                g_wb = desc_wr_valid; g_wb_word = desc_wr_word; g_wb_idx = desc_wr_idx;
                g_lat = c;
            end else if (desc_rd_req && !acked) begin
                g_rd = 1'b1; g_rd_idx = desc_rd_idx;
                if (wait_n == ack_delay) begin
                    desc_rd_ack = 1'b1; desc_found = found; desc_rd_word = word;
                    acked = 1'b1;
                end
                wait_n++;
            end
            if (!got) @(negedge clk);
        end
        desc_rd_ack = 1'b0;
    endtask

    task automatic predict(input bit wr, input logic [AW-1:0] addr, input logic [3:0] nb,
                           input bit be, input bit found, input logic [DW-1:0] word,
                           input int ack_delay);
        int off = int'(addr) % 4096;
        int lsb = ((int'(addr) / 4096) % 2 == 1) ? EL : NL;
        int oldp = int'((word >> lsb) & 32'd3);
        int newp = oldp;
        int ret = 0;
        e_ntf = 1'b0; e_wb = 1'b0; e_err = 1'b0; e_data = 64'h0; e_wb_word = word;
        if (nb != 4'd8 || !be || (wr && off >= 2048)) begin
            e_err = 1'b1; e_rd = 1'b0; e_lat = 0;
            e_data = wr ? 64'h0 : {64{1'b1}};
            return;
        end
        e_rd = 1'b1; e_lat = ack_delay + 1;
        if (!found || !word[VB]) begin
            e_err = 1'b1; e_data = wr ? 64'h0 : {64{1'b1}};
            return;
        end
        if (!wr && off >= 3072) begin
            newp = (off / 256) % 4; ret = oldp;
        end else if (!wr && off >= 2048) begin
            ret = oldp;
        end else if (wr && off < 1024) begin
            if (oldp == 0) begin newp = 2; e_ntf = 1'b1; end
            else if (oldp == 1) newp = 1;
            else newp = 3;
        end else begin
            if (oldp % 2 == 1) begin newp = 2; e_ntf = 1'b1; end
            else newp = 0;
            ret = e_ntf ? 1 : 0;
        end
        e_data = wr ? 64'h0 : 64'(ret);
        if (newp != oldp) begin
            e_wb = 1'b1;
            e_wb_word = (word & ~(32'd3 << lsb)) | (32'(newp) << lsb);
        end
    endtask

    task automatic run_and_check(input string tag, input bit wr, input logic [AW-1:0] addr,
                                 input logic [3:0] nb, input bit be, input bit found,
                                 input logic [DW-1:0] word, input int ack_delay);
        predict(wr, addr, nb, be, found, word, ack_delay);
        access(wr, addr, nb, be, found, word, ack_delay);
        check(g_lat == e_lat, {tag, " R11 response cycle"}, 64'(g_lat), 64'(e_lat));
        check(g_data == e_data, {tag, " data"}, g_data, e_data);
        check(g_err == e_err, {tag, " err"}, 64'(g_err), 64'(e_err));
        check(g_ntf == e_ntf, {tag, " notify"}, 64'(g_ntf), 64'(e_ntf));
        check(g_rd == e_rd, {tag, " descriptor read"}, 64'(g_rd), 64'(e_rd));
        if (e_rd)
            check(g_rd_idx == QW'(addr >> (PS + 1)), {tag, " R1 queue index"},
                  64'(g_rd_idx), 64'(addr >> (PS + 1)));
        check(g_wb == e_wb, {tag, " R10 write-back strobe"}, 64'(g_wb), 64'(e_wb));
        if (e_wb) begin
            check(g_wb_word == e_wb_word, {tag, " R10 write-back word"},
                  64'(g_wb_word), 64'(e_wb_word));
            check(g_wb_idx == QW'(addr >> (PS + 1)), {tag, " R10 write-back index"},
                  64'(g_wb_idx), 64'(addr >> (PS + 1)));
        end
    endtask

    function automatic logic [DW-1:0] make_word(input int par, input int pv);
        logic [DW-1:0] w = 32'hA5C3_0F96;
        int tl = (par == 1) ? EL : NL;
        int ol = (par == 1) ? NL : EL;
        w = w & ~(32'd3 << NL) & ~(32'd3 << EL);
        w = w | (32'(pv) << tl) | (32'(3 - pv) << ol);
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string opname [8] = '{"R5 R6 load-EOI", "R3 GET", "R4 set-00", "R4 set-01",
                              "R4 set-10", "R4 set-11", "R7 trigger", "R8 R6 store-EOI"};
        int base [8] = '{'h000, 'h800, 'hC00, 'hD00, 'hE00, 'hF00, 'h000, 'h400};
        int span [8] = '{'h800, 'h400, 'h100, 'h100, 'h100, 'h100, 'h400, 'h400};
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && desc_rd_req == 1'b0 &&
              desc_wr_valid == 1'b0, "R11 reset state",
              {60'h0, req_ready, rsp_valid, desc_rd_req, desc_wr_valid}, 64'h8);
        rst_n = 1'b1;

        // sweep: both parities, every starting pair, every operation range
        for (int par = 0; par < 2; par++) begin
            for (int pv = 0; pv < 4; pv++) begin
                for (int op = 0; op < 8; op++) begin
                    int q = (pv * 3 + op + par * 5) % 8;
                    int off = base[op] + ((pv * 37 + op * 11 + par * 250) % span[op]);
                    logic [AW-1:0] a = AW'((q << (PS + 1)) | (par << PS) | off);
                    run_and_check(opname[op], op >= 6, a, 4'd8, 1'b1, 1'b1,
                                  make_word(par, pv), (pv + op) % 3);
                end
            end
        end

        // R2 access shape rejection
        run_and_check("R2 load 4-byte", 1'b0, 16'h2900, 4'd4, 1'b1, 1'b1, make_word(0, 1), 0);
        run_and_check("R2 load little-endian", 1'b0, 16'h3C00, 4'd8, 1'b0, 1'b1,
                      make_word(0, 1), 0);
        run_and_check("R2 store 2-byte", 1'b1, 16'h4000, 4'd2, 1'b1, 1'b1, make_word(0, 0), 0);
        // R8 store offsets above the EOI range
        run_and_check("R8 store at 0x800", 1'b1, 16'h5800, 4'd8, 1'b1, 1'b1, make_word(0, 0), 0);
        run_and_check("R8 store at 0xFFF", 1'b1, 16'h7FFF, 4'd8, 1'b1, 1'b1, make_word(1, 0), 0);
        // R9 descriptor missing or invalid
        run_and_check("R9 load missing", 1'b0, 16'h2C00, 4'd8, 1'b1, 1'b0, make_word(0, 1), 1);
        run_and_check("R9 load invalid", 1'b0, 16'h3E00, 4'd8, 1'b1, 1'b1,
                      make_word(1, 0) & 32'h7FFF_FFFF, 0);
        run_and_check("R9 store invalid", 1'b1, 16'h1000, 4'd8, 1'b1, 1'b1,
                      make_word(1, 0) & 32'h7FFF_FFFF, 2);
        // R11 back-to-back accesses with long acknowledge delay
        run_and_check("R11 long wait trigger", 1'b1, 16'hF123, 4'd8, 1'b1, 1'b1,
                      make_word(1, 0), 5);
        run_and_check("R11 long wait GET", 1'b0, 16'hE9FF, 4'd8, 1'b1, 1'b1,
                      make_word(0, 3), 4);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule